// File: doc/BRIEF.md
# 16-bit Programmable Pulse Generator Timer

This block is a 16-bit up-counter that produces a PWM waveform. One 16-bit compare value sets the period. A second 16-bit compare value sets how long the output stays at its active level. When the counter reaches the period value, a period match occurs: the counter returns to zero, an interrupt flag is set, and newly written compare values are moved from their buffers into the active comparators. Software can therefore change the period or duty at any time without producing a torn cycle.

A selectable prescaler supplies the count tick. It offers seven divided rates of the fast clock enable, plus a synchronised external clock pin whose counting edge can be chosen. The block runs either continuously or for a single period. In single-period operation the run bit drops by itself once the period ends.

Software reaches the block through a byte-wide register port. This port has no handshake: a write is taken on every clock edge where `reg_wr_i` is high, and the read data is a combinational function of `reg_addr_i`. The output pin and the interrupt request are plain level signals.

Register map, by address (all fields reset to zero):

- 0 (control): bit 7 is run. Bits 5:4 are mode: 10 = single period, 11 = continuous, 0x = counter stopped. Writing 1 to bit 0 clears the counter; this bit always reads as 0.
- 1 (config): bits 6:4 select the clock. Bit 3 is the period-match flag: writing 0 clears it and writing 1 has no effect. Bit 2 is the output polarity. Bit 1 selects the external edge: 0 = rising, 1 = falling.
- 2 and 3: low and high byte of the period buffer.
- 4 and 5: low and high byte of the duty buffer.
- 6 and 7: low and high byte of the live counter (read only).

Top module: `ppg_timer16`

## Requirements
- R1: After reset, registers 0 and 1 read as 0x00, the counter reads 0, `pwm_o` is low and `irq_o` is low.
- R2: Clock select values 0 to 6 advance the counter once every 1, 2, 4, 8, 64, 512 and 2048 cycles of `cken_i` respectively, using a free-running divider. While `cken_i` is low the counter does not advance.
- R3: With period value A, the counter counts 0 to A and returns to 0 on the tick taken at A, so each period lasts A+1 ticks.
- R4: With polarity 0 and duty value B, the output is high for the first B ticks of each period and low for the rest. If B is greater than or equal to A, the output is high for the whole period. If B is 0, the output is low for the whole period.
- R5: Setting the polarity bit inverts the running waveform. While the block is stopped, the output rests at the polarity value.
- R6: A write to a high byte is held aside and does not change the buffer. A write to a low byte updates the whole 16-bit buffer. Buffer contents reach the active comparators only at a period match.
- R7: In mode 10 the block runs for one period. At the period match the run bit clears by itself, and the counter then stays at 0.
- R8: Each period match sets the flag, and `irq_o` follows the flag. Writing 0 to config bit 3 clears the flag, and writing 1 leaves it unchanged. A clear written in the same cycle as a period match loses, so the flag ends up set.
- R9: Writing 1 to control bit 0 sets the counter to 0 on that clock edge.
- R10: With clock select 7, the counter advances once for each edge of `ext_clk_i` of the kind chosen by config bit 1, after synchronisation. Edges of the other kind are ignored.
- R11: While run is 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cken_i | input | 1 | Fast clock enable feeding the prescaler |
| ext_clk_i | input | 1 | External count clock pin, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| pwm_o | output | 1 | Registered PWM output |
| irq_o | output | 1 | Period-match interrupt request |

## Verification
Two events can fall in the same cycle: the period match setting the flag, and a software write that clears the flag. The bench clears the counter and starts the timer from a known edge. It then counts clock edges so that the flag-clearing write is taken on exactly the edge where the counter leaves the period value. The check is judged at the port: `irq_o` must still be high after that edge. A later write, on an edge with no match, must bring it low.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = 11;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL    = 3'd0,
    ADDR_CFG     = 3'd1,
    ADDR_PER_LO  = 3'd2,
    ADDR_PER_HI  = 3'd3,
    ADDR_DUTY_LO = 3'd4,
    ADDR_DUTY_HI = 3'd5,
    ADDR_CNT_LO  = 3'd6,
    ADDR_CNT_HI  = 3'd7
  } addr_e;

  typedef enum logic [1:0] {
    MODE_STOP     = 2'b00,
    MODE_STOP_ALT = 2'b01,
    MODE_ONESHOT  = 2'b10,
    MODE_REPEAT   = 2'b11
  } mode_e;

  localparam logic [2:0] SEL_EXT = 3'd7;

  // divider exponent for each internal clock select code
  function automatic int div_exp(input logic [2:0] sel);
    case (sel)
      3'd0:    div_exp = 0;
      3'd1:    div_exp = 1;
      3'd2:    div_exp = 2;
      3'd3:    div_exp = 3;
      3'd4:    div_exp = 6;
      3'd5:    div_exp = 9;
      3'd6:    div_exp = 11;
      default: div_exp = 0;
    endcase
  endfunction
endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler
  import ppg_pkg::*;
#(
  parameter int DW    = DIV_W,
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cken_i,
  input  logic       ext_i,
  input  logic [2:0] clksel_i,
  input  logic       edge_fall_i,
  output logic       tick_o
);
  logic [DW-1:0]     div_q;
  logic [DW-1:0]     mask;
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              ext_s, ext_rise, ext_fall, int_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (cken_i) div_q <= div_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (i < div_exp(clksel_i));
  end

  assign int_tick = cken_i && (&(div_q | ~mask));

  generate
    if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ext_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_N-2:0], ext_i};
      end
    end
  endgenerate

  assign ext_s = sync_q[SYNC_N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= ext_s;
  end

  assign ext_rise = ext_s & ~prev_q;
  assign ext_fall = ~ext_s & prev_q;
  assign tick_o   = (clksel_i == SEL_EXT) ? (edge_fall_i ? ext_fall : ext_rise) : int_tick;

  AST_DIV_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && clksel_i != 3'd0 && clksel_i != SEL_EXT) |=> (!tick_o || clksel_i != $past(clksel_i))) // R2
    else $error("divided tick longer than one cycle");
endmodule

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          a_match_i,
  input  logic [CW-1:0] cnt_i,
  output logic          active_o,
  output logic          clr_o,
  output logic [2:0]    clksel_o,
  output logic          pol_o,
  output logic          edge_fall_o,
  output logic          flag_o,
  output logic [CW-1:0] buf_a_o,
  output logic [CW-1:0] buf_b_o
);
  logic          run_q;
  mode_e         mode_q;
  logic [2:0]    clksel_q;
  logic          pol_q, edge_q, flag_q;
  logic [DW-1:0] a_hold_q, b_hold_q;
  logic [CW-1:0] buf_a_q, buf_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      mode_q   <= MODE_STOP;
      clksel_q <= '0;
      pol_q    <= 1'b0;
      edge_q   <= 1'b0;
      flag_q   <= 1'b0;
      a_hold_q <= '0;
      b_hold_q <= '0;
      buf_a_q  <= '0;
      buf_b_q  <= '0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          ADDR_CTRL: begin
            run_q  <= wdata_i[7];
            mode_q <= mode_e'(wdata_i[5:4]);
          end
          ADDR_CFG: begin
            clksel_q <= wdata_i[6:4];
            pol_q    <= wdata_i[2];
            edge_q   <= wdata_i[1];
            if (!wdata_i[3]) flag_q <= 1'b0;
          end
          ADDR_PER_HI:  a_hold_q <= wdata_i;
          ADDR_PER_LO:  buf_a_q  <= {a_hold_q, wdata_i};
          ADDR_DUTY_HI: b_hold_q <= wdata_i;
          ADDR_DUTY_LO: buf_b_q  <= {b_hold_q, wdata_i};
          default: ;
        endcase
      end
      if (a_match_i) begin
        flag_q <= 1'b1;
        if (mode_q == MODE_ONESHOT) run_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL:    rdata_o = {run_q, 1'b0, mode_q, 4'b0000};
      ADDR_CFG:     rdata_o = {1'b0, clksel_q, flag_q, pol_q, edge_q, 1'b0};
      ADDR_PER_LO:  rdata_o = buf_a_q[DW-1:0];
      ADDR_PER_HI:  rdata_o = buf_a_q[CW-1:DW];
      ADDR_DUTY_LO: rdata_o = buf_b_q[DW-1:0];
      ADDR_DUTY_HI: rdata_o = buf_b_q[CW-1:DW];
      ADDR_CNT_LO:  rdata_o = cnt_i[DW-1:0];
      default:      rdata_o = cnt_i[CW-1:DW];
    endcase
  end

  assign active_o    = run_q && mode_q[1];
  assign clr_o       = wr_i && (addr_i == ADDR_CTRL) && wdata_i[0];
  assign clksel_o    = clksel_q;
  assign pol_o       = pol_q;
  assign edge_fall_o = edge_q;
  assign flag_o      = flag_q;
  assign buf_a_o     = buf_a_q;
  assign buf_b_o     = buf_b_q;

  AST_ONESHOT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_match_i && mode_q == MODE_ONESHOT) |=> !run_q) // R7
    else $error("single period did not clear run");
  AST_FLAG_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_match_i |=> flag_q) // R8
    else $error("match did not set flag");
endmodule

// File: rtl/ppg_core.sv
module ppg_core
  import ppg_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          active_i,
  input  logic          clr_i,
  input  logic          pol_i,
  input  logic [CW-1:0] buf_a_i,
  input  logic [CW-1:0] buf_b_i,
  output logic [CW-1:0] cnt_o,
  output logic          a_match_o,
  output logic          pwm_o
);
  logic [CW-1:0] cnt_q, act_a_q, act_b_q;
  logic          level, pwm_q;

  assign a_match_o = active_i && tick_i && (cnt_q == act_a_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      act_a_q <= '0;
      act_b_q <= '0;
    end else begin
      if (clr_i || a_match_o)        cnt_q <= '0;
      else if (active_i && tick_i)   cnt_q <= cnt_q + 1'b1;
      if (a_match_o) begin
        act_a_q <= buf_a_i;
        act_b_q <= buf_b_i;
      end
    end
  end

  always_comb begin
    if (act_b_q == '0)            level = 1'b0;
    else if (act_b_q >= act_a_q)  level = 1'b1;
    else                          level = (cnt_q < act_b_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= active_i ? (level ^ pol_i) : pol_i;
  end

  assign cnt_o = cnt_q;
  assign pwm_o = pwm_q;

  AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_a_q) // R3
    else $error("counter passed period value");
  AST_RELOAD_ONLY_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_match_o |=> ($stable(act_a_q) && $stable(act_b_q))) // R6
    else $error("compare values changed without match");
  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)) // R9
    else $error("counter clear ignored");
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !clr_i) |=> $stable(cnt_q)) // R11
    else $error("counter moved while stopped");
endmodule

// File: rtl/ppg_timer16.sv
module ppg_timer16
  import ppg_pkg::*;
#(
  parameter int CW     = CNT_W,
  parameter int DW     = DATA_W,
  parameter int AW     = ADDR_W,
  parameter int PRE_W  = DIV_W,
  parameter int SYNC_N = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cken_i,
  input  logic          ext_clk_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          pwm_o,
  output logic          irq_o
);
  logic          tick, active, clr, pol, edge_fall, a_match, flag;
  logic [2:0]    clksel;
  logic [CW-1:0] buf_a, buf_b, cnt;

  ppg_regs #(.CW(CW), .DW(DW), .AW(AW)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .a_match_i  (a_match),
    .cnt_i      (cnt),
    .active_o   (active),
    .clr_o      (clr),
    .clksel_o   (clksel),
    .pol_o      (pol),
    .edge_fall_o(edge_fall),
    .flag_o     (flag),
    .buf_a_o    (buf_a),
    .buf_b_o    (buf_b)
  );

  ppg_prescaler #(.DW(PRE_W), .SYNC_N(SYNC_N)) pre_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cken_i     (cken_i),
    .ext_i      (ext_clk_i),
    .clksel_i   (clksel),
    .edge_fall_i(edge_fall),
    .tick_o     (tick)
  );

  ppg_core #(.CW(CW)) core_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .active_i (active),
    .clr_i    (clr),
    .pol_i    (pol),
    .buf_a_i  (buf_a),
    .buf_b_i  (buf_b),
    .cnt_o    (cnt),
    .a_match_o(a_match),
    .pwm_o    (pwm_o)
  );

  assign irq_o = flag;

  AST_IRQ_FOLLOWS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(a_match)) // R8
    else $error("irq rose without period match");
endmodule

// File: tb/ppg_timer16_tb_top.sv
module ppg_timer16_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] C_RUN = 8'h80, C_ONE = 8'h20, C_REP = 8'h30, C_CLR = 8'h01;

  logic       clk = 1'b0, rst_n = 1'b0, cken = 1'b1, ext = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       pwm, irq;
  int n_tests = 0, n_fail = 0;

  ppg_timer16 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cken_i(cken), .ext_clk_i(ext),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pwm_o(pwm), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); h += int'(pwm); end
  endtask

  task automatic t_reset();
    int v;
    rd_reg(3'd0, v); chk("R1 ctrl", v, 0);
    rd_reg(3'd1, v); chk("R1 cfg", v, 0);
    rd_reg(3'd6, v); chk("R1 cnt", v, 0);
    chk("R1 pwm", int'(pwm), 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_buffer();
    int v;
    wr_reg(3'd3, 8'h12);
    rd_reg(3'd3, v); chk("R6 high byte held", v, 0);
    wr_reg(3'd2, 8'h34);
    rd_reg(3'd3, v); chk("R6 commit hi", v, 8'h12);
    rd_reg(3'd2, v); chk("R6 commit lo", v, 8'h34);
    wr_reg(3'd3, 8'h00); wr_reg(3'd2, 8'd9);
    wr_reg(3'd5, 8'h00); wr_reg(3'd4, 8'd4);
    wr_reg(3'd0, C_RUN | C_REP);
    repeat (5) @(negedge clk);
    wr_reg(3'd0, C_REP);
    wr_reg(3'd0, C_REP | C_CLR);
    rd_reg(3'd6, v); chk("R9 clear", v, 0);
    wr_reg(3'd2, 8'd5);
    wr_reg(3'd0, C_RUN | C_REP);
    repeat (7) @(negedge clk);
    rd_reg(3'd6, v); chk("R6 old period still active", v, 7);
    repeat (3) @(negedge clk);
    rd_reg(3'd6, v); chk("R3 wrap at period", v, 0);
    repeat (5) @(negedge clk);
    rd_reg(3'd6, v); chk("R6 new period loaded", v, 5);
    @(negedge clk);
    rd_reg(3'd6, v); chk("R3 wrap at new period", v, 0);
  endtask

  task automatic t_duty();
    int h;
    wr_reg(3'd2, 8'd9);
    repeat (30) @(negedge clk);
    count_high(30, h); chk("R4 duty 4 of 10", h, 12);
    chk("R8 irq after match", int'(irq), 1);
    wr_reg(3'd4, 8'd12);
    repeat (30) @(negedge clk);
    count_high(30, h); chk("R4 duty above period", h, 30);
    wr_reg(3'd4, 8'd0);
    repeat (30) @(negedge clk);
    count_high(30, h); chk("R4 duty zero", h, 0);
    wr_reg(3'd4, 8'd4);
    repeat (30) @(negedge clk);
  endtask

  task automatic t_polarity_hold();
    int h, v0, v1;
    wr_reg(3'd1, 8'h04);
    repeat (5) @(negedge clk);
    count_high(30, h); chk("R5 inverted duty", h, 18);
    wr_reg(3'd0, C_REP);
    repeat (2) @(negedge clk);
    chk("R5 idle at polarity 1", int'(pwm), 1);
    rd_reg(3'd6, v0);
    repeat (20) @(negedge clk);
    rd_reg(3'd6, v1); chk("R11 hold while stopped", v1, v0);
    wr_reg(3'd1, 8'h00);
    repeat (2) @(negedge clk);
    chk("R5 idle at polarity 0", int'(pwm), 0);
  endtask

  task automatic t_oneshot();
    int h, v;
    wr_reg(3'd0, C_ONE | C_CLR);
    wr_reg(3'd0, C_RUN | C_ONE);
    count_high(30, h); chk("R7 single pulse width", h, 4);
    rd_reg(3'd0, v); chk("R7 run cleared", v, 8'h20);
    rd_reg(3'd6, v); chk("R7 counter rests at 0", v, 0);
  endtask

  task automatic t_irq();
    wr_reg(3'd1, 8'h00);
    chk("R8 flag cleared", int'(irq), 0);
    wr_reg(3'd1, 8'h08);
    chk("R8 write 1 no effect", int'(irq), 0);
    wr_reg(3'd0, C_REP | C_CLR);
    wr_reg(3'd0, C_RUN | C_REP);
    repeat (8) @(negedge clk);
    wr_reg(3'd1, 8'h00);
    chk("R8 set wins over clear", int'(irq), 1);
    wr_reg(3'd1, 8'h00);
    chk("R8 later clear works", int'(irq), 0);
  endtask

  task automatic t_prescale();
    int v0, v1;
    wr_reg(3'd3, 8'hFF); wr_reg(3'd2, 8'hFF);
    repeat (20) @(negedge clk);
    rd_reg(3'd6, v0); repeat (64) @(negedge clk); rd_reg(3'd6, v1);
    chk("R2 fx/1", (v1 - v0) & 255, 64);
    wr_reg(3'd1, 8'h30);
    rd_reg(3'd6, v0); repeat (64) @(negedge clk); rd_reg(3'd6, v1);
    chk("R2 fx/8", (v1 - v0) & 255, 8);
    cken = 1'b0;
    rd_reg(3'd6, v0); repeat (64) @(negedge clk); rd_reg(3'd6, v1);
    chk("R2 enable low freezes", (v1 - v0) & 255, 0);
    cken = 1'b1;
    wr_reg(3'd1, 8'h60);
    rd_reg(3'd6, v0); repeat (4096) @(negedge clk); rd_reg(3'd6, v1);
    chk("R2 fx/2048", (v1 - v0) & 255, 2);
  endtask

  task automatic t_ext();
    int v0, v1;
    wr_reg(3'd1, 8'h70);
    repeat (4) @(negedge clk);
    rd_reg(3'd6, v0);
    repeat (3) begin
      ext = 1'b1; repeat (6) @(negedge clk);
      ext = 1'b0; repeat (6) @(negedge clk);
    end
    rd_reg(3'd6, v1); chk("R10 rising edges", (v1 - v0) & 255, 3);
    wr_reg(3'd1, 8'h72);
    rd_reg(3'd6, v0);
    ext = 1'b1; repeat (6) @(negedge clk);
    rd_reg(3'd6, v1); chk("R10 rising ignored in falling mode", (v1 - v0) & 255, 0);
    ext = 1'b0; repeat (6) @(negedge clk);
    rd_reg(3'd6, v1); chk("R10 falling edge counted", (v1 - v0) & 255, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_buffer();
    t_duty();
    t_polarity_hold();
    t_oneshot();
    t_irq();
    t_prescale();
    t_ext();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule